// File: doc/BRIEF.md
# Per-Core Watchdog Policy Register Bank

This block holds the watchdog policy state for a group of processor cores in a small memory-mapped register space. Each core has one control/status word and one read-only locator word. Software uses the control word to pause that core's watchdog timer and to allow a core reset on a second timer expiry. The external timer logic reads back a pause level and a reset-enable level for each core.

Pausing takes a magic code byte written to a write-only field. Resuming takes a write-one-to-clear bit. The reset enable is a write-one-to-set bit that hardware forces low whenever the core's power-active input is low. When the external timer reports a second expiry for a core whose reset enable is set, the block pulses a core-reset request for that core. Reads are registered, so data appears one cycle after the read strobe.

Top module: `wdog_ctl_bank`

## Requirements
- R1: Core c's control word is at byte address c*0x20+0x04 and its locator word at c*0x20+0x08. Read data appears on `rdata` in the cycle after `rd_en` and is zero in every other cycle.
- R2: A control write whose bits 7:0 equal 0x76 sets the paused flag (bit 8). A write with any other code byte leaves the flag unchanged.
- R3: A control write with bit 8 set clears the paused flag, and a write with bit 8 clear leaves it unchanged. If one write carries both the 0x76 code and bit 8, the clear wins.
- R4: A control write with bit 9 set sets the reset enable while the core is power-active. A write with bit 9 clear leaves it unchanged.
- R5: While `core_active[c]` is low, the reset enable of core c is cleared on the next clock edge. This clear takes priority over a set written in the same cycle.
- R6: `core_rst_req[c]` is high in the cycle after `second_expiry[c]` is seen high while the reset enable is set. It stays low when the enable is clear.
- R7: The locator word reads bits 20:0 = 0x78300 + 0x100*c, bits 23:21 = version 0, and zero above that. Writes to it have no effect.
- R8: Control word reads return bit 8 = paused, bit 9 = reset enable, and zero in bits 7:0 and 31:10. Bits 31:10 of a write are ignored.
- R9: `wd_pause` follows the paused flags and `wd_rst_en` follows the reset enables. Reset clears both flags and `rdata`.
- R10: Addresses at other offsets, or with a core index of NUM_CORES or more, read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low local reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| core_active | input | NUM_CORES | Per-core power-active indication |
| second_expiry | input | NUM_CORES | Per-core second timer expiry event from the timer |
| wd_pause | output | NUM_CORES | Per-core pause level to the timer |
| wd_rst_en | output | NUM_CORES | Per-core second-timeout reset enable |
| core_rst_req | output | NUM_CORES | Per-core one-cycle reset request |

## Verification
The control word is written with the exact code, with a near-miss code, with the clear bit alone, with the code and the clear bit together, and with all ones. Together these separate a code compare from a bit test and show which of two simultaneous requests wins. The reads cover locator words for the first and last core, an unused offset and an out-of-range core. These confirm that the stride and offset decode picks one core and no alias. The directed part drops power-active around a set write and pulses expiry events with the enable both set and clear. This ties the reset request to the enable rather than to the event alone.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

  localparam logic [7:0] PAUSE_CODE = 8'h76;
  localparam int unsigned PAUSED_BIT = 8;
  localparam int unsigned RSTEN_BIT  = 9;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CS   = 2'd1,
    SEL_PTR  = 2'd2
  } reg_sel_e;

  // Locator word of one core: offset field, version field, zero above.
  function automatic logic [31:0] locator_word(
    input int unsigned core,
    input int unsigned base,
    input int unsigned step,
    input logic [2:0]  ver
  );
    logic [20:0] ofs;
    ofs = 21'(base + step * core);
    return {8'h00, ver, ofs};
  endfunction

  // Control/status read image: code field reads zero.
  function automatic logic [31:0] ctl_word(input logic paused, input logic rst_en);
    logic [31:0] w;
    w = '0;
    w[PAUSED_BIT] = paused;
    w[RSTEN_BIT]  = rst_en;
    return w;
  endfunction

endpackage

// File: rtl/wdc_addr_dec.sv
module wdc_addr_dec
  import wdc_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned STRIDE_LG2 = 5,
  parameter int unsigned CS_OFS     = 4,
  parameter int unsigned PTR_OFS    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CORES-1:0] core_oh,
  output reg_sel_e             sel
);

  localparam int unsigned IDX_W = ADDR_W - STRIDE_LG2;

  logic [IDX_W-1:0]      idx;
  logic [STRIDE_LG2-1:0] ofs;

  assign idx = addr[ADDR_W-1:STRIDE_LG2];
  assign ofs = addr[STRIDE_LG2-1:0];

  always_comb begin
    if (ofs == STRIDE_LG2'(CS_OFS))       sel = SEL_CS;
    else if (ofs == STRIDE_LG2'(PTR_OFS)) sel = SEL_PTR;
    else                                  sel = SEL_NONE;
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
    assign core_oh[i] = (idx == IDX_W'(i)) && (sel != SEL_NONE);
  end

endmodule

// File: rtl/wdc_core_regs.sv
module wdc_core_regs
  import wdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_wr,
  input  logic [9:0] wdata,
  input  logic       core_active,
  input  logic       second_expiry,
  output logic       paused,
  output logic       rst_en,
  output logic       rst_req
);

  logic pause_set_ev;
  logic pause_clr_ev;
  logic en_set_ev;
  logic en_clr_ev;

  assign pause_set_ev = cs_wr && (wdata[7:0] == PAUSE_CODE);
  assign pause_clr_ev = cs_wr && wdata[PAUSED_BIT];
  assign en_set_ev    = cs_wr && wdata[RSTEN_BIT];
  assign en_clr_ev    = !core_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused <= 1'b0;
    end else if (pause_clr_ev) begin
      paused <= 1'b0;
    end else if (pause_set_ev) begin
      paused <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en <= 1'b0;
    end else if (en_clr_ev) begin
      rst_en <= 1'b0;
    end else if (en_set_ev) begin
      rst_en <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= second_expiry && rst_en;
  end

endmodule

// File: rtl/wdc_rd_mux.sv
module wdc_rd_mux
  import wdc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned PTR_BASE  = 32'h0007_8300,
  parameter int unsigned PTR_STEP  = 32'h100,
  parameter logic [2:0]  VERSION   = 3'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [NUM_CORES-1:0] core_oh,
  input  reg_sel_e             sel,
  input  logic [NUM_CORES-1:0] paused,
  input  logic [NUM_CORES-1:0] rst_en,
  output logic [31:0]          rdata
);

  logic [31:0] core_word [NUM_CORES];
  logic [31:0] rd_mux;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_word
    assign core_word[i] = (sel == SEL_PTR)
                        ? locator_word(i, PTR_BASE, PTR_STEP, VERSION)
                        : ctl_word(paused[i], rst_en[i]);
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (core_oh[i]) rd_mux = rd_mux | core_word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

endmodule

// File: rtl/wdog_ctl_bank.sv
module wdog_ctl_bank
  import wdc_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned STRIDE_LG2 = 5,
  parameter int unsigned CS_OFS     = 4,
  parameter int unsigned PTR_OFS    = 8,
  parameter int unsigned PTR_BASE   = 32'h0007_8300,
  parameter int unsigned PTR_STEP   = 32'h100,
  parameter logic [2:0]  VERSION    = 3'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NUM_CORES-1:0] core_active,
  input  logic [NUM_CORES-1:0] second_expiry,
  output logic [NUM_CORES-1:0] wd_pause,
  output logic [NUM_CORES-1:0] wd_rst_en,
  output logic [NUM_CORES-1:0] core_rst_req
);

  logic [NUM_CORES-1:0] core_oh;
  reg_sel_e             sel;
  logic [NUM_CORES-1:0] cs_wr_vec;
  logic [NUM_CORES-1:0] paused_vec;
  logic [NUM_CORES-1:0] rst_en_vec;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:10];

  wdc_addr_dec #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .STRIDE_LG2(STRIDE_LG2),
    .CS_OFS    (CS_OFS),
    .PTR_OFS   (PTR_OFS)
  ) u_dec (
    .addr   (addr),
    .core_oh(core_oh),
    .sel    (sel)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assign cs_wr_vec[i] = wr_en && core_oh[i] && (sel == SEL_CS);

    wdc_core_regs u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_wr        (cs_wr_vec[i]),
      .wdata        (wdata[9:0]),
      .core_active  (core_active[i]),
      .second_expiry(second_expiry[i]),
      .paused       (paused_vec[i]),
      .rst_en       (rst_en_vec[i]),
      .rst_req      (core_rst_req[i])
    );
  end

  wdc_rd_mux #(
    .NUM_CORES(NUM_CORES),
    .PTR_BASE (PTR_BASE),
    .PTR_STEP (PTR_STEP),
    .VERSION  (VERSION)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .core_oh(core_oh),
    .sel    (sel),
    .paused (paused_vec),
    .rst_en (rst_en_vec),
    .rdata  (rdata)
  );

  assign wd_pause  = paused_vec;
  assign wd_rst_en = rst_en_vec;

endmodule

// File: rtl/wdc_checker.sv
module wdc_checker #(
  parameter int unsigned NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] core_oh,
  input logic [NUM_CORES-1:0] cs_wr,
  input logic [31:0]          wdata,
  input logic [NUM_CORES-1:0] core_active,
  input logic [NUM_CORES-1:0] second_expiry,
  input logic [NUM_CORES-1:0] wd_pause,
  input logic [NUM_CORES-1:0] wd_rst_en,
  input logic [NUM_CORES-1:0] core_rst_req
);

  AST_ONE_CORE_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_oh)); // R1

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    AST_PAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_wr[i] && (wdata[7:0] == 8'h76) && !wdata[8] |=> wd_pause[i]); // R2

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_wr[i] |=> $stable(wd_pause[i])); // R2

    AST_PAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cs_wr[i] && wdata[8] |=> !wd_pause[i]); // R3

    AST_RSTEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_wr[i] && wdata[9] && core_active[i] |=> wd_rst_en[i]); // R4

    AST_RSTEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !core_active[i] |=> !wd_rst_en[i]); // R5

    AST_REQ_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      second_expiry[i] && wd_rst_en[i] |=> core_rst_req[i]); // R6

    AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(second_expiry[i] && wd_rst_en[i]) |=> !core_rst_req[i]); // R6
  end

endmodule

bind wdog_ctl_bank wdc_checker #(.NUM_CORES(NUM_CORES)) u_wdc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_oh      (core_oh),
  .cs_wr        (cs_wr_vec),
  .wdata        (wdata),
  .core_active  (core_active),
  .second_expiry(second_expiry),
  .wd_pause     (wd_pause),
  .wd_rst_en    (wd_rst_en),
  .core_rst_req (core_rst_req)
);

// File: tb/test_wdog_ctl_bank.sv
module test_wdog_ctl_bank;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] core_active = '1;
  logic [N-1:0] second_expiry = '0;
  logic [N-1:0] wd_pause, wd_rst_en, core_rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_ctl_bank i_wdog_ctl_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .core_active(core_active),
    .second_expiry(second_expiry), .wd_pause(wd_pause),
    .wd_rst_en(wd_rst_en), .core_rst_req(core_rst_req)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        is_wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd9,  1'b0, 12'h004, 32'h0,        32'h0},        // R9 reset image
    '{4'd7,  1'b0, 12'h008, 32'h0,        32'h0007_8300},// R7 core0 locator
    '{4'd7,  1'b0, 12'h068, 32'h0,        32'h0007_8600},// R7 core3 locator
    '{4'd2,  1'b1, 12'h004, 32'h76,       32'h0},        // R2 code
    '{4'd2,  1'b0, 12'h004, 32'h0,        32'h100},      // R2 paused set
    '{4'd2,  1'b1, 12'h024, 32'h75,       32'h0},        // R2 near-miss code
    '{4'd2,  1'b0, 12'h024, 32'h0,        32'h0},        // R2 unchanged
    '{4'd3,  1'b1, 12'h004, 32'h0,        32'h0},        // R3 zero write
    '{4'd3,  1'b0, 12'h004, 32'h0,        32'h100},      // R3 still paused
    '{4'd3,  1'b1, 12'h004, 32'h100,      32'h0},        // R3 clear
    '{4'd3,  1'b0, 12'h004, 32'h0,        32'h0},        // R3 cleared
    '{4'd3,  1'b1, 12'h044, 32'h176,      32'h0},        // R3 code+clear
    '{4'd3,  1'b0, 12'h044, 32'h0,        32'h0},        // R3 clear wins
    '{4'd4,  1'b1, 12'h044, 32'h200,      32'h0},        // R4 set enable
    '{4'd4,  1'b0, 12'h044, 32'h0,        32'h200},      // R4 enable read
    '{4'd4,  1'b1, 12'h044, 32'h0,        32'h0},        // R4 zero write
    '{4'd4,  1'b0, 12'h044, 32'h0,        32'h200},      // R4 kept
    '{4'd7,  1'b1, 12'h008, 32'hFFFF_FFFF,32'h0},        // R7 write locator
    '{4'd7,  1'b0, 12'h008, 32'h0,        32'h0007_8300},// R7 unchanged
    '{4'd10, 1'b1, 12'h084, 32'h276,      32'h0},        // R10 core index 4
    '{4'd10, 1'b0, 12'h084, 32'h0,        32'h0},        // R10 reads zero
    '{4'd10, 1'b0, 12'h00C, 32'h0,        32'h0},        // R10 bad offset
    '{4'd8,  1'b1, 12'h064, 32'hFFFF_FFFF,32'h0},        // R8 all ones
    '{4'd8,  1'b0, 12'h064, 32'h0,        32'h200}       // R8 image
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 pause at reset", 32'(wd_pause), 32'h0);
    chk("R9 rst_en at reset", 32'(wd_rst_en), 32'h0);
    chk("R6 req at reset", 32'(core_rst_req), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata idle", rdata, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].is_wr) begin
        do_write(VECS[k].a, VECS[k].d);
      end else begin
        do_read(VECS[k].a, rd);
        chk($sformatf("R%0d vec%0d", VECS[k].req, k), rd, VECS[k].exp);
      end
    end

    // R1: rdata returns to zero the cycle after the read
    @(negedge clk);
    chk("R1 rdata after read", rdata, 32'h0);
    // R9 outputs follow flags: core2 and core3 enabled, none paused
    chk("R9 wd_rst_en", 32'(wd_rst_en), 32'hC);
    chk("R9 wd_pause", 32'(wd_pause), 32'h0);
    do_write(12'h024, 32'h76);
    chk("R9 wd_pause core1", 32'(wd_pause), 32'h2);

    // R6 expiry with enable set on core3, and with enable clear on core0
    @(negedge clk);
    second_expiry = 4'b1001;
    @(negedge clk);
    second_expiry = '0;
    chk("R6 req pulse", 32'(core_rst_req), 32'h8);
    @(negedge clk);
    chk("R6 req one cycle", 32'(core_rst_req), 32'h0);

    // R5 power-active low clears enable of core2
    core_active[2] = 1'b0;
    @(negedge clk);
    chk("R5 enable dropped", 32'(wd_rst_en), 32'h8);
    do_write(12'h044, 32'h200);
    chk("R5 set blocked while inactive", 32'(wd_rst_en), 32'h8);
    core_active[2] = 1'b1;
    do_read(12'h044, rd);
    chk("R5 readback", rd, 32'h0);
    second_expiry[2] = 1'b1;
    @(negedge clk);
    second_expiry = '0;
    chk("R6 no req when disabled", 32'(core_rst_req), 32'h0);

    // R9 local reset clears flags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 pause after reset", 32'(wd_pause), 32'h0);
    chk("R9 rst_en after reset", 32'(wd_rst_en), 32'h0);
    do_read(12'h024, rd);
    chk("R9 core1 image after reset", rd, 32'h0);

    done = 1'b1;
    summary();
  end

endmodule